// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block decides when a small microcontroller runs, naps or sleeps. Software writes two byte-wide control registers over a simple read/write port. From those writes the block derives the enables for the fast and slow oscillators, the main clock select, and the halt signals for the CPU, the watchdog, the peripherals and the time base. It also derives the port pad mode and a reset request when software asks for an oscillator setting that would leave the chip without a clock.

There are three low-power states. A light idle halts only the CPU and the watchdog. A deeper clock-halt also gates the peripheral clocks but keeps the time base running. A full stop turns both oscillators off. The first two end as soon as an interrupt is pending. Stop ends only through a wake pin, which is sensed either on its rising edge or while it is high. After the wake, the block restarts the chosen oscillator and counts a selectable warm-up period in that oscillator's ticks before it lets the CPU run again. It then resumes either on the fast clock or on the slow clock, as configured. All logic runs on one system clock, and each oscillator contributes a one-cycle tick enable.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, register 1 (addr 0) reads 0x00 and register 2 (addr 1) reads 0x80. At that point osc_fast_en=1, osc_slow_en=0, clk_sel_slow=0, and all halt, port and reset-request outputs are 0.
- R2: Register 1 holds STOP in bit 7, wake-level select in bit 6, slow-return select in bit 5, port-keep in bit 4 and warm-up select in bits 3:2; bits 1:0 read 0. Register 2 holds fast-oscillator enable in bit 7, slow-oscillator enable in bit 6, clock select in bit 5, idle in bit 4 and clock-halt in bit 2; bits 3, 1 and 0 read 0. Writes take effect on the next clock edge.
- R3: A write of register 1 with bit 7 set, made while running, enters stop on the next edge. In stop, cpu_halt, periph_halt and tbase_halt are 1, both oscillator enables are 0, and bit 7 reads 1.
- R4: Throughout stop and warm-up, port_hiz equals the inverse of the port-keep bit and wake_pad_hiz is 1. Both are 0 outside these states.
- R5: With wake-level select 0, stop is released only by a rising edge of wake_pin (0 on one edge, 1 on the next). A wake_pin already high on entry does not release.
- R6: With wake-level select 1, stop is released on the edge after wake_pin is sampled high.
- R7: The warm-up counts only ticks of the resumed oscillator. The CPU halt drops on the edge that samples the N-th such tick. For a fast return, selects 0..3 give N = 3·2^FL, 2^FL, 3·2^FS, 2^FS. For a slow return they give N = 3·2^SL, 2^SL, 3·2^SS, 2^SS.
- R8: When stop is released with slow-return 0, register 2 becomes fast on, slow off, clock select 0. With slow-return 1 it becomes fast off, slow on, clock select 1. The resumed oscillator is enabled during warm-up, and bit 7 of register 1 reads 0 once the CPU resumes.
- R9: Outside stop, osc_fast_en, osc_slow_en and clk_sel_slow follow register 2 bits 7, 6 and 5, and at least one oscillator enable is high.
- R10: A register 2 write that clears both oscillator enables, clears the fast enable with clock select 0, or clears the slow enable with clock select 1 leaves register 2 unchanged. It makes rst_req 1 for exactly the one cycle after the write.
- R11: Setting idle halts only the CPU (cpu_halt=1, periph_halt=0), and bit 4 reads 1. Register writes made while not running are ignored.
- R12: Setting clock-halt gives cpu_halt=1, periph_halt=1 and tbase_halt=0. If both idle and clock-halt are written, clock-halt wins.
- R13: irq_pend ends idle or clock-halt on the next edge, clearing the bit, with no warm-up. It has no effect while running or in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 mode register, 1 clock register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| fast_tick | input | 1 | One-cycle tick of the fast oscillator |
| slow_tick | input | 1 | One-cycle tick of the slow oscillator |
| wake_pin | input | 1 | Stop release input, active high |
| irq_pend | input | 1 | Interrupt pending, ends idle and clock-halt |
| osc_fast_en | output | 1 | Fast oscillator enable |
| osc_slow_en | output | 1 | Slow oscillator enable |
| clk_sel_slow | output | 1 | Main clock select, 1 = slow |
| cpu_halt | output | 1 | CPU and watchdog halt |
| periph_halt | output | 1 | Peripheral clock gate (time base excluded) |
| tbase_halt | output | 1 | Time base halt |
| port_hiz | output | 1 | Port outputs to high impedance |
| wake_pad_hiz | output | 1 | Wake pad forced to input |
| rst_req | output | 1 | Reset request for an illegal oscillator write |

## Verification
The bench builds the block with warm-up exponents FL=4, FS=2, SL=3 and SS=1. With these, every one of the eight warm-up lengths (48, 16, 12, 4 fast ticks; 24, 8, 6, 2 slow ticks) runs to its end within a short test, and the tick just before the end is checked as well as the end itself. Spurious ticks from the other oscillator are placed between the counted ones, so counting on the wrong source shows up as an early or late release.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    M_RUN  = 3'd0,
    M_IDLE = 3'd1,
    M_TGH  = 3'd2,
    M_STOP = 3'd3,
    M_WARM = 3'd4
  } lpm_mode_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  lpm_mode_e  mode,
  input  logic       release_go,
  output logic [7:0] rdata,
  output logic       req_stop,
  output logic       req_idle,
  output logic       req_tgh,
  output logic       rel_lvl,
  output logic       ret_slow,
  output logic       port_keep,
  output logic [1:0] wu_sel,
  output logic       fast_en,
  output logic       slow_en,
  output logic       clk_slow,
  output logic       rst_req
);
  logic       running;
  logic       wr_mode, wr_clk, illegal;
  logic       rel_lvl_d, ret_slow_d, port_keep_d;
  logic [1:0] wu_sel_d;
  logic       fast_en_d, slow_en_d, clk_slow_d;
  logic [3:0] wdata_unused;

  assign running = (mode == M_RUN);
  assign wr_mode = wr_en & ~addr & running;
  assign wr_clk  = wr_en &  addr & running;

  assign illegal = wr_clk & ((~wdata[7] & ~wdata[6]) |
                             (~wdata[7] & ~wdata[5]) |
                             (~wdata[6] &  wdata[5]));

  assign req_stop = wr_mode & wdata[7];
  assign req_idle = wr_clk & ~illegal & wdata[4];
  assign req_tgh  = wr_clk & ~illegal & wdata[2];
  assign wdata_unused = {wdata[3], wdata[1:0], 1'b0};

  always_comb begin
    rel_lvl_d   = rel_lvl;
    ret_slow_d  = ret_slow;
    port_keep_d = port_keep;
    wu_sel_d    = wu_sel;
    if (wr_mode) begin
      rel_lvl_d   = wdata[6];
      ret_slow_d  = wdata[5];
      port_keep_d = wdata[4];
      wu_sel_d    = wdata[3:2];
    end
  end

  always_comb begin
    fast_en_d  = fast_en;
    slow_en_d  = slow_en;
    clk_slow_d = clk_slow;
    if (release_go) begin
      fast_en_d  = ~ret_slow;
      slow_en_d  =  ret_slow;
      clk_slow_d =  ret_slow;
    end else if (wr_clk && !illegal) begin
      fast_en_d  = wdata[7];
      slow_en_d  = wdata[6];
      clk_slow_d = wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_lvl   <= 1'b0;
      ret_slow  <= 1'b0;
      port_keep <= 1'b0;
      wu_sel    <= 2'b00;
      fast_en   <= 1'b1;
      slow_en   <= 1'b0;
      clk_slow  <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      rel_lvl   <= rel_lvl_d;
      ret_slow  <= ret_slow_d;
      port_keep <= port_keep_d;
      wu_sel    <= wu_sel_d;
      fast_en   <= fast_en_d;
      slow_en   <= slow_en_d;
      clk_slow  <= clk_slow_d;
      rst_req   <= illegal;
    end
  end

  always_comb begin
    if (addr) begin
      rdata = {fast_en, slow_en, clk_slow, (mode == M_IDLE), 1'b0,
               (mode == M_TGH), 2'b00};
    end else begin
      rdata = {((mode == M_STOP) || (mode == M_WARM)), rel_lvl, ret_slow,
               port_keep, wu_sel, 2'b00};
    end
  end
endmodule

// File: rtl/lpm_warmup.sv
module lpm_warmup #(
  parameter int FL = 16,
  parameter int FS = 14,
  parameter int SL = 13,
  parameter int SS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  logic       slow_sel,
  input  logic [1:0] wu_sel,
  input  logic       fast_tick,
  input  logic       slow_tick,
  output logic       done
);
  localparam int MAXE = (FL > SL) ? FL : SL;
  localparam int CW   = MAXE + 2;

  logic [CW-1:0] cnt_q, cnt_d, len;
  logic          tick;

  always_comb begin
    case ({slow_sel, wu_sel})
      3'b000:  len = CW'(3) << FL;
      3'b001:  len = CW'(1) << FL;
      3'b010:  len = CW'(3) << FS;
      3'b011:  len = CW'(1) << FS;
      3'b100:  len = CW'(3) << SL;
      3'b101:  len = CW'(1) << SL;
      3'b110:  len = CW'(3) << SS;
      default: len = CW'(1) << SS;
    endcase
  end

  assign tick = slow_sel ? slow_tick : fast_tick;
  assign done = active & tick & (cnt_q == len - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (active && tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_stop,
  input  logic      req_idle,
  input  logic      req_tgh,
  input  logic      rel_lvl,
  input  logic      wake_pin,
  input  logic      irq_pend,
  input  logic      warm_done,
  output lpm_mode_e mode,
  output logic      release_go
);
  lpm_mode_e mode_d;
  logic      wake_q, wake_hit;

  assign wake_hit = rel_lvl ? wake_pin : (wake_pin & ~wake_q);

  always_comb begin
    mode_d     = mode;
    release_go = 1'b0;
    case (mode)
      M_RUN: begin
        if (req_stop)      mode_d = M_STOP;
        else if (req_tgh)  mode_d = M_TGH;
        else if (req_idle) mode_d = M_IDLE;
      end
      M_IDLE, M_TGH: begin
        if (irq_pend) mode_d = M_RUN;
      end
      M_STOP: begin
        if (wake_hit) begin
          mode_d     = M_WARM;
          release_go = 1'b1;
        end
      end
      M_WARM: begin
        if (warm_done) mode_d = M_RUN;
      end
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_RUN;
      wake_q <= 1'b0;
    end else begin
      mode   <= mode_d;
      wake_q <= wake_pin;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int FL = 16,
  parameter int FS = 14,
  parameter int SL = 13,
  parameter int SS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic       wake_pin,
  input  logic       irq_pend,
  output logic       osc_fast_en,
  output logic       osc_slow_en,
  output logic       clk_sel_slow,
  output logic       cpu_halt,
  output logic       periph_halt,
  output logic       tbase_halt,
  output logic       port_hiz,
  output logic       wake_pad_hiz,
  output logic       rst_req
);
  logic       rst_ns;
  lpm_mode_e  mode;
  logic       release_go, warm_done;
  logic       req_stop, req_idle, req_tgh;
  logic       rel_lvl, ret_slow, port_keep;
  logic [1:0] wu_sel;
  logic       fast_en, slow_en, clk_slow;
  logic       stopped, osc_off;

  lpm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  lpm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .mode       (mode),
    .release_go (release_go),
    .rdata      (rdata),
    .req_stop   (req_stop),
    .req_idle   (req_idle),
    .req_tgh    (req_tgh),
    .rel_lvl    (rel_lvl),
    .ret_slow   (ret_slow),
    .port_keep  (port_keep),
    .wu_sel     (wu_sel),
    .fast_en    (fast_en),
    .slow_en    (slow_en),
    .clk_slow   (clk_slow),
    .rst_req    (rst_req)
  );

  lpm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_ns),
    .req_stop   (req_stop),
    .req_idle   (req_idle),
    .req_tgh    (req_tgh),
    .rel_lvl    (rel_lvl),
    .wake_pin   (wake_pin),
    .irq_pend   (irq_pend),
    .warm_done  (warm_done),
    .mode       (mode),
    .release_go (release_go)
  );

  lpm_warmup #(.FL(FL), .FS(FS), .SL(SL), .SS(SS)) u_warm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .clr       (release_go),
    .active    (mode == M_WARM),
    .slow_sel  (ret_slow),
    .wu_sel    (wu_sel),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .done      (warm_done)
  );

  assign stopped      = (mode == M_STOP) || (mode == M_WARM);
  assign osc_off      = (mode == M_STOP);
  assign osc_fast_en  = fast_en & ~osc_off;
  assign osc_slow_en  = slow_en & ~osc_off;
  assign clk_sel_slow = clk_slow;
  assign cpu_halt     = (mode != M_RUN);
  assign periph_halt  = stopped || (mode == M_TGH);
  assign tbase_halt   = stopped;
  assign port_hiz     = stopped & ~port_keep;
  assign wake_pad_hiz = stopped;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      wr_en,
  input logic      addr,
  input logic      fast_tick,
  input logic      slow_tick,
  input logic      wake_pin,
  input logic      irq_pend,
  input logic      rel_lvl,
  input lpm_mode_e mode,
  input logic      osc_fast_en,
  input logic      osc_slow_en,
  input logic      port_hiz,
  input logic      wake_pad_hiz,
  input logic      rst_req
);
  AST_RSTREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R10
  AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(wr_en) && $past(addr))); // R10
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && !rel_lvl && !wake_pin) |=> (mode == M_STOP)); // R5
  AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && rel_lvl && wake_pin) |=> (mode == M_WARM)); // R6
  AST_WARM_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WARM && !fast_tick && !slow_tick) |=> (mode == M_WARM)); // R7
  AST_IRQ_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_IDLE || mode == M_TGH) && irq_pend) |=> (mode == M_RUN)); // R13
  AST_OSC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_STOP) |-> (osc_fast_en || osc_slow_en)); // R9
  AST_PAD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    port_hiz |-> wake_pad_hiz); // R4
endmodule

bind lpm_ctrl lpm_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .fast_tick    (fast_tick),
  .slow_tick    (slow_tick),
  .wake_pin     (wake_pin),
  .irq_pend     (irq_pend),
  .rel_lvl      (rel_lvl),
  .mode         (mode),
  .osc_fast_en  (osc_fast_en),
  .osc_slow_en  (osc_slow_en),
  .port_hiz     (port_hiz),
  .wake_pad_hiz (wake_pad_hiz),
  .rst_req      (rst_req)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;
  localparam int FL = 4;
  localparam int FS = 2;
  localparam int SL = 3;
  localparam int SS = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       fast_tick = 1'b0;
  logic       slow_tick = 1'b0;
  logic       wake_pin = 1'b0;
  logic       irq_pend = 1'b0;
  logic       osc_fast_en, osc_slow_en, clk_sel_slow;
  logic       cpu_halt, periph_halt, tbase_halt;
  logic       port_hiz, wake_pad_hiz, rst_req;

  int total = 0;
  int bad = 0;
  logic [7:0] r2_exp;

  always #5 clk = ~clk;

  lpm_ctrl #(.FL(FL), .FS(FS), .SL(SL), .SS(SS)) i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wake_pin(wake_pin), .irq_pend(irq_pend), .osc_fast_en(osc_fast_en),
    .osc_slow_en(osc_slow_en), .clk_sel_slow(clk_sel_slow),
    .cpu_halt(cpu_halt), .periph_halt(periph_halt), .tbase_halt(tbase_halt),
    .port_hiz(port_hiz), .wake_pad_hiz(wake_pad_hiz), .rst_req(rst_req)
  );

  function automatic int warm_len(input logic slow, input logic [1:0] sel);
    int e;
    if (slow) e = sel[1] ? SS : SL;
    else      e = sel[1] ? FS : FL;
    return sel[0] ? (1 << e) : (3 << e);
  endfunction

  function automatic logic osc_legal(input logic [7:0] d);
    return !((!d[7] && !d[6]) || (!d[7] && !d[5]) || (!d[6] && d[5]));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
  endtask

  task automatic run_stop(input logic relm, input logic retm, input logic keep,
                          input logic [1:0] sel, input logic pre_high);
    logic [7:0] v;
    logic [7:0] cfg;
    int n;
    cfg = {1'b0, relm, retm, keep, sel, 2'b00};
    n = warm_len(retm, sel);
    wake_pin = pre_high & ~relm;
    wr(1'b0, cfg | 8'h80);
    chk("R3 cpu_halt in stop", cpu_halt, 1);
    chk("R3 periph/tbase halt in stop", {periph_halt, tbase_halt}, 2'b11);
    chk("R3 oscillators off in stop", {osc_fast_en, osc_slow_en}, 2'b00);
    rd(1'b0, v);
    chk("R3 stop bit reads 1", v, cfg | 8'h80);
    chk("R4 port_hiz in stop", port_hiz, !keep);
    chk("R4 wake pad input in stop", wake_pad_hiz, 1);
    pulse_irq();
    chk("R13 irq ignored in stop", cpu_halt, 1);
    if (!relm && pre_high) begin
      repeat (3) @(negedge clk);
      chk("R5 high wake at entry holds stop", {osc_fast_en, osc_slow_en}, 2'b00);
      wake_pin = 1'b0;
      @(negedge clk);
      chk("R5 falling wake holds stop", {osc_fast_en, osc_slow_en}, 2'b00);
    end
    wake_pin = 1'b1;
    @(negedge clk);
    wake_pin = 1'b0;
    if (relm) chk("R6 level release starts warm-up", {osc_fast_en, osc_slow_en}, {!retm, retm});
    else      chk("R5 rising edge starts warm-up", {osc_fast_en, osc_slow_en}, {!retm, retm});
    chk("R8 clock select after release", clk_sel_slow, retm);
    chk("R4 port mode held in warm-up", {port_hiz, wake_pad_hiz}, {!keep, 1'b1});
    chk("R8 cpu held in warm-up", cpu_halt, 1);
    for (int k = 1; k <= n; k++) begin
      int gap;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (retm) fast_tick = 1'b1; else slow_tick = 1'b1;
      end
      @(negedge clk);
      fast_tick = !retm; slow_tick = retm;
      @(negedge clk);
      fast_tick = 1'b0; slow_tick = 1'b0;
      if (k == n - 1) chk("R7 still halted one tick before end", cpu_halt, 1);
      if (k == n)     chk("R7 cpu resumes after last tick", cpu_halt, 0);
    end
    rd(1'b0, v);
    chk("R8 stop bit cleared", v, cfg);
    rd(1'b1, v);
    chk("R8 clock register after return", v, retm ? 8'h60 : 8'h80);
    chk("R4 ports released", {port_hiz, wake_pad_hiz}, 2'b00);
    wr(1'b1, 8'h80);
    r2_exp = 8'h80;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1357));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 reg1 reset", v, 8'h00);
    rd(1'b1, v); chk("R1 reg2 reset", v, 8'h80);
    chk("R1 oscillators after reset", {osc_fast_en, osc_slow_en, clk_sel_slow}, 3'b100);
    chk("R1 halts after reset", {cpu_halt, periph_halt, tbase_halt, port_hiz, wake_pad_hiz, rst_req}, 6'd0);

    // R2 layout and unused bits
    wr(1'b0, 8'h7F);
    rd(1'b0, v); chk("R2 reg1 unused bits read 0", v, 8'h7C);
    wr(1'b1, 8'hCB);
    rd(1'b1, v); chk("R2 reg2 unused bits read 0", v, 8'hC0);
    chk("R9 both oscillators on", {osc_fast_en, osc_slow_en, clk_sel_slow}, 3'b110);
    r2_exp = 8'hC0;
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      d = 8'($urandom) & 8'h7F;
      wr(1'b0, d);
      rd(1'b0, v); chk("R2 random reg1 readback", v, d & 8'h7C);
    end
    wr(1'b0, 8'h00);

    // R9/R10 random oscillator writes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      logic ok;
      d = {3'($urandom), 5'b00000};
      ok = osc_legal(d);
      wr(1'b1, d);
      chk("R10 rst_req for write", rst_req, !ok);
      if (ok) r2_exp = d;
      rd(1'b1, v); chk("R10 reg2 after write", v, r2_exp);
      chk("R9 oscillator outputs", {osc_fast_en, osc_slow_en, clk_sel_slow}, r2_exp[7:5]);
      @(negedge clk);
      chk("R10 rst_req is one cycle", rst_req, 0);
    end
    wr(1'b1, 8'h00);
    chk("R10 both off requests reset", rst_req, 1);
    wr(1'b1, 8'h80);
    r2_exp = 8'h80;
    rd(1'b1, v); chk("R9 back to fast clock", v, 8'h80);

    // R11 idle
    wr(1'b1, 8'h90);
    chk("R11 idle halts cpu only", {cpu_halt, periph_halt, tbase_halt}, 3'b100);
    rd(1'b1, v); chk("R11 idle bit reads 1", v, 8'h90);
    wr(1'b0, 8'h10);
    rd(1'b0, v); chk("R11 write while idle ignored", v, 8'h00);
    pulse_irq();
    chk("R13 irq ends idle", cpu_halt, 0);
    rd(1'b1, v); chk("R13 idle bit cleared", v, 8'h80);

    // R12 clock-halt with priority
    wr(1'b1, 8'h94);
    chk("R12 clock-halt gates peripherals", {cpu_halt, periph_halt, tbase_halt}, 3'b110);
    rd(1'b1, v); chk("R12 clock-halt wins over idle", v, 8'h84);
    pulse_irq();
    chk("R13 irq ends clock-halt", {cpu_halt, periph_halt}, 2'b00);
    rd(1'b1, v); chk("R13 clock-halt bit cleared", v, 8'h80);
    pulse_irq();
    chk("R13 irq in run has no effect", cpu_halt, 0);
    rd(1'b1, v); chk("R13 reg2 unchanged by irq in run", v, 8'h80);

    // Stop cycles: directed corners then random
    run_stop(1'b0, 1'b0, 1'b0, 2'd3, 1'b1);
    run_stop(1'b1, 1'b1, 1'b1, 2'd3, 1'b0);
    run_stop(1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    run_stop(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      run_stop(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule